// File: doc/BRIEF.md
# Video RAM Block-Copy DMA Engine

This block copies data from system memory into the 8 KiB video RAM window at 0x8000–0x9FFF, in units of 16-byte chunks. Software programs the engine through a byte-wide register port: four address bytes (source and destination, high and low) and a control byte. The control byte holds the mode and the chunk count, and writing it launches the copy. The engine then acts as a bus master and moves the data one byte at a time. Each byte takes one read request followed by one write request, and each request is held until the memory system acknowledges it.

There are two modes. In the stalling mode the whole copy runs at once, and the CPU-stall output stays high until the last byte has been written. In the line-paced mode the engine moves one chunk each time the horizontal-blank input rises. Before it starts anything, the engine checks the aligned source address and the LCD-enable input. It may refuse the copy, park the request, or accept it. Each outcome leaves its own value in the control readback, and software polls that value to learn the outcome and the progress of the copy.

Top module: `vdma_engine`

## Requirements
- R1: After reset the control readback (register index 4) is 0xFF, address registers (indices 0 to 3: source high, source low, destination high, destination low) read 0x00, cpu_stall is low and no bus request is issued.
- R2: The source is {index0, index1} with its low 4 bits cleared; if that aligned value lies in 0x8000–0x9FFF the control write starts nothing and the control readback becomes the written byte with bit 7 set.
- R3: A control write with bit 7 = 1 (line-paced mode) while lcd_on is low, and a valid source, starts nothing and the control readback becomes 0x80 | ((written + 1) & 0x7F).
- R4: An accepted control write makes the control readback equal the written byte with bit 7 cleared; bits 6:0 of the write give the chunk count minus one, and bit 7 = 0 selects the stalling mode.
- R5: The destination start is ({index2, index3} & 0x1FF0) | 0x8000; byte k of the copy is read from aligned source + k and written to destination + k, where the destination adds within its low 13 bits so it wraps inside 0x8000–0x9FFF; each written byte equals the byte read just before it.
- R6: In the stalling mode, cpu_stall goes high in the cycle after the accepted control write and stays high until the last byte's write is acknowledged; (count + 1) × 16 bytes are moved.
- R7: In the line-paced mode, no bus request is made until a rising edge on hblank; each rising edge moves exactly 16 bytes, cpu_stall stays low, and the control readback bits 6:0 go down by one after each chunk that is not the last.
- R8: When the final chunk completes, the control readback becomes 0xFF and the engine becomes idle.
- R9: A control write while a copy is in progress is ignored: the readback, the mode and the remaining work do not change.
- R10: Every bus request is held, with unchanged address, data and direction, until bus_ack is high; each byte uses one read (bus_we low) and then one write (bus_we high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_idx |
| lcd_on | input | 1 | Display enable state |
| hblank | input | 1 | Horizontal-blank level; rising edge paces line mode |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 = write request, 0 = read request |
| bus_addr | output | 16 | Request address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Request accepted this cycle |
| bus_rdata | input | 8 | Read data, valid with bus_ack on a read |
| cpu_stall | output | 1 | Holds the CPU during a stalling-mode copy |

## Verification
The assertions assume that the memory system leaves bus_ack low whenever no request is pending, and that bus_rdata is valid in any cycle where a read is acknowledged. The bench's memory model raises its acknowledge only while a request is present, at a random rate. It drives the read data from a fixed function of the address, so every written byte can be traced back to its source. The bench drives the hblank pulses only while the engine is waiting between chunks. It also issues control writes during a copy on purpose, so that the ignore rule is exercised within these assumptions.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int ADDR_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int LEN_BITS = 7;
    localparam int IDX_W    = 3;

    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] WIN_SPAN = 16'h1FFF;

    localparam logic [IDX_W-1:0] IDX_SRC_HI = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SRC_LO = 3'd1;
    localparam logic [IDX_W-1:0] IDX_DST_HI = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DST_LO = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        V_GO     = 2'd0,
        V_REJECT = 2'd1,
        V_PARK   = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } mstate_e;

endpackage

// File: rtl/vdma_launch.sv
module vdma_launch
    import vdma_pkg::*;
#(
    parameter int CHUNK_BYTES = 16
) (
    input  logic [BYTE_W-1:0]   src_hi,
    input  logic [BYTE_W-1:0]   src_lo,
    input  logic [BYTE_W-1:0]   dst_hi,
    input  logic [BYTE_W-1:0]   dst_lo,
    input  logic [BYTE_W-1:0]   ctrl_wdata,
    input  logic                lcd_on,
    output verdict_e            verdict,
    output logic [BYTE_W-1:0]   verdict_rb,
    output logic [ADDR_W-1:0]   go_src,
    output logic [ADDR_W-1:0]   go_dst,
    output logic                go_hmode,
    output logic [LEN_BITS-1:0] go_left
);

    localparam int CHUNK_W = $clog2(CHUNK_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << CHUNK_W;
    localparam logic [ADDR_W-1:0] DST_MASK   = WIN_SPAN & ALIGN_MASK;

    logic [ADDR_W-1:0] src_aligned;
    logic              src_in_window;

    always_comb begin
        src_aligned   = {src_hi, src_lo} & ALIGN_MASK;
        src_in_window = (src_aligned >= WIN_BASE) && (src_aligned <= (WIN_BASE | WIN_SPAN));

        go_src   = src_aligned;
        go_dst   = ({dst_hi, dst_lo} & DST_MASK) | WIN_BASE;
        go_hmode = ctrl_wdata[BYTE_W-1];
        go_left  = ctrl_wdata[LEN_BITS-1:0];

        if (src_in_window) begin
            verdict    = V_REJECT;
            verdict_rb = ctrl_wdata | 8'h80;
        end else if (go_hmode && !lcd_on) begin
            verdict    = V_PARK;
            verdict_rb = {1'b1, ctrl_wdata[LEN_BITS-1:0] + 7'd1};
        end else begin
            verdict    = V_GO;
            verdict_rb = {1'b0, ctrl_wdata[LEN_BITS-1:0]};
        end
    end

endmodule

// File: rtl/vdma_regfile.sv
module vdma_regfile
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic [BYTE_W-1:0] verdict_rb,
    input  logic              chunk_done,
    input  logic              xfer_done,
    output logic [BYTE_W-1:0] src_hi,
    output logic [BYTE_W-1:0] src_lo,
    output logic [BYTE_W-1:0] dst_hi,
    output logic [BYTE_W-1:0] dst_lo,
    output logic [BYTE_W-1:0] ctrl_rb
);

    typedef struct packed {
        logic [BYTE_W-1:0] src_hi;
        logic [BYTE_W-1:0] src_lo;
        logic [BYTE_W-1:0] dst_hi;
        logic [BYTE_W-1:0] dst_lo;
        logic [BYTE_W-1:0] rb;
    } regs_s;

    regs_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (idx)
                IDX_SRC_HI: r_d.src_hi = wdata;
                IDX_SRC_LO: r_d.src_lo = wdata;
                IDX_DST_HI: r_d.dst_hi = wdata;
                IDX_DST_LO: r_d.dst_lo = wdata;
                default:    ;
            endcase
        end
        if (wr_en && idx == IDX_CTRL && !busy) begin
            r_d.rb = verdict_rb;
        end else if (chunk_done) begin
            if (xfer_done) begin
                r_d.rb = 8'hFF;
            end else begin
                r_d.rb = {r_q.rb[BYTE_W-1], r_q.rb[LEN_BITS-1:0] - 7'd1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{src_hi: '0, src_lo: '0, dst_hi: '0, dst_lo: '0, rb: 8'hFF};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (idx)
            IDX_SRC_HI: rdata = r_q.src_hi;
            IDX_SRC_LO: rdata = r_q.src_lo;
            IDX_DST_HI: rdata = r_q.dst_hi;
            IDX_DST_LO: rdata = r_q.dst_lo;
            IDX_CTRL:   rdata = r_q.rb;
            default:    rdata = 8'hFF;
        endcase
    end

    assign src_hi  = r_q.src_hi;
    assign src_lo  = r_q.src_lo;
    assign dst_hi  = r_q.dst_hi;
    assign dst_lo  = r_q.dst_lo;
    assign ctrl_rb = r_q.rb;

    // R8: the mover's own count must agree with the readback on the last chunk
    a_r8_last_chunk_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (r_q.rb[LEN_BITS-1:0] == '0) && !r_q.rb[BYTE_W-1]);

    // R8: completion leaves the idle readback
    a_r8_done_readback: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (r_q.rb == 8'hFF));

endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
    import vdma_pkg::*;
#(
    parameter int CHUNK_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_hmode,
    input  logic [ADDR_W-1:0]   start_src,
    input  logic [ADDR_W-1:0]   start_dst,
    input  logic [LEN_BITS-1:0] start_left,
    input  logic                hblank,
    input  logic                bus_ack,
    input  logic [BYTE_W-1:0]   bus_rdata,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [BYTE_W-1:0]   bus_wdata,
    output logic                busy,
    output logic                cpu_stall,
    output logic                chunk_done,
    output logic                xfer_done
);

    localparam int CHUNK_W = $clog2(CHUNK_BYTES);
    localparam logic [CHUNK_W-1:0] LAST_BYTE = CHUNK_W'(CHUNK_BYTES - 1);
    localparam int WIN_W = $clog2(int'(WIN_SPAN) + 1);

    typedef struct packed {
        mstate_e             state;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [BYTE_W-1:0]   data;
        logic [CHUNK_W-1:0]  byte_idx;
        logic [LEN_BITS-1:0] left;
        logic                hmode;
        logic                hb_prev;
    } mov_s;

    mov_s m_q, m_d;

    always_comb begin
        m_d        = m_q;
        chunk_done = 1'b0;
        xfer_done  = 1'b0;
        m_d.hb_prev = hblank;
        case (m_q.state)
            S_IDLE: begin
                if (start) begin
                    m_d.src      = start_src;
                    m_d.dst      = start_dst;
                    m_d.left     = start_left;
                    m_d.hmode    = start_hmode;
                    m_d.byte_idx = '0;
                    m_d.state    = start_hmode ? S_WAIT : S_READ;
                end
            end
            S_WAIT: begin
                if (hblank && !m_q.hb_prev) begin
                    m_d.state = S_READ;
                end
            end
            S_READ: begin
                if (bus_ack) begin
                    m_d.data  = bus_rdata;
                    m_d.state = S_WRITE;
                end
            end
            S_WRITE: begin
                if (bus_ack) begin
                    m_d.src      = m_q.src + 16'd1;
                    m_d.dst      = {m_q.dst[ADDR_W-1:WIN_W], m_q.dst[WIN_W-1:0] + WIN_W'(1)};
                    m_d.byte_idx = m_q.byte_idx + CHUNK_W'(1);
                    m_d.state    = S_READ;
                    if (m_q.byte_idx == LAST_BYTE) begin
                        chunk_done = 1'b1;
                        if (m_q.left == '0) begin
                            xfer_done = 1'b1;
                            m_d.state = S_IDLE;
                        end else begin
                            m_d.left  = m_q.left - 7'd1;
                            m_d.state = m_q.hmode ? S_WAIT : S_READ;
                        end
                    end
                end
            end
            default: m_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '{state: S_IDLE, src: '0, dst: '0, data: '0, byte_idx: '0,
                     left: '0, hmode: 1'b0, hb_prev: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    always_comb begin
        bus_req   = (m_q.state == S_READ) || (m_q.state == S_WRITE);
        bus_we    = (m_q.state == S_WRITE);
        bus_addr  = bus_we ? m_q.dst : m_q.src;
        bus_wdata = m_q.data;
        busy      = (m_q.state != S_IDLE);
        cpu_stall = busy && !m_q.hmode;
    end

    // R10: a pending request keeps its direction, address and data
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R10: an acknowledged read is always followed by a write
    a_r10_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

    // R5: every write lands inside the video window
    a_r5_dest_window: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> ((bus_addr & ~WIN_SPAN) == WIN_BASE));

    // R6: the stall is released once the copy completes
    a_r6_stall_released: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !cpu_stall);

endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int CHUNK_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    input  logic                lcd_on,
    input  logic                hblank,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [BYTE_W-1:0]   bus_wdata,
    input  logic                bus_ack,
    input  logic [BYTE_W-1:0]   bus_rdata,
    output logic                cpu_stall
);

    logic [BYTE_W-1:0]   src_hi, src_lo, dst_hi, dst_lo, ctrl_rb;
    logic [BYTE_W-1:0]   verdict_rb;
    verdict_e            verdict;
    logic [ADDR_W-1:0]   go_src, go_dst;
    logic                go_hmode;
    logic [LEN_BITS-1:0] go_left;
    logic                busy, chunk_done, xfer_done;
    logic                ctrl_write, start;

    assign ctrl_write = reg_wr && (reg_idx == IDX_CTRL);
    assign start      = ctrl_write && !busy && (verdict == V_GO);

    vdma_launch #(.CHUNK_BYTES(CHUNK_BYTES)) u_launch (
        .src_hi     (src_hi),
        .src_lo     (src_lo),
        .dst_hi     (dst_hi),
        .dst_lo     (dst_lo),
        .ctrl_wdata (reg_wdata),
        .lcd_on     (lcd_on),
        .verdict    (verdict),
        .verdict_rb (verdict_rb),
        .go_src     (go_src),
        .go_dst     (go_dst),
        .go_hmode   (go_hmode),
        .go_left    (go_left)
    );

    vdma_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .busy       (busy),
        .verdict_rb (verdict_rb),
        .chunk_done (chunk_done),
        .xfer_done  (xfer_done),
        .src_hi     (src_hi),
        .src_lo     (src_lo),
        .dst_hi     (dst_hi),
        .dst_lo     (dst_lo),
        .ctrl_rb    (ctrl_rb)
    );

    vdma_mover #(.CHUNK_BYTES(CHUNK_BYTES)) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_hmode (go_hmode),
        .start_src   (go_src),
        .start_dst   (go_dst),
        .start_left  (go_left),
        .hblank      (hblank),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .cpu_stall   (cpu_stall),
        .chunk_done  (chunk_done),
        .xfer_done   (xfer_done)
    );

    // R2, R3: a refused control write leaves the engine idle
    a_r3_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !busy && verdict != V_GO) |=> !busy);

    // R4: an accepted control write starts the engine
    a_r4_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !busy && verdict == V_GO) |=> busy);

    // R9: a control write during a copy leaves the readback alone unless a chunk ends
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && busy && !chunk_done) |=> $stable(ctrl_rb));

    // R7: the line-paced mode never stalls the CPU
    a_r7_no_stall_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !busy && verdict == V_GO && go_hmode) |=> !cpu_stall);

endmodule

// File: tb/vdma_engine_test.sv
`timescale 1ns/1ps
module vdma_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd4;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        lcd_on = 1'b1;
    logic        hblank = 1'b0;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        cpu_stall;

    int checks = 0;
    int errors = 0;

    logic [15:0] log_addr [0:2047];
    logic [7:0]  log_data [0:2047];
    int          nlog = 0;

    always #4 clk = ~clk;

    vdma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcd_on(lcd_on),
        .hblank(hblank), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [15:0] exp_src(input logic [7:0] hi, input logic [7:0] lo);
        return {hi, lo} & 16'hFFF0;
    endfunction

    function automatic logic [15:0] exp_dst(input logic [7:0] hi, input logic [7:0] lo);
        return ({hi, lo} & 16'h1FF0) | 16'h8000;
    endfunction

    // 0 accepted, 1 rejected source, 2 parked
    function automatic int exp_verdict(input logic [15:0] src, input logic [7:0] w, input logic lcd);
        if (src >= 16'h8000 && src <= 16'h9FFF) return 1;
        if (w[7] && !lcd) return 2;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rb(input int v, input logic [7:0] w);
        if (v == 1) return w | 8'h80;
        if (v == 2) return {1'b1, w[6:0] + 7'd1};
        return {1'b0, w[6:0]};
    endfunction

    // memory model: acknowledges only pending requests, at a random rate
    always @(negedge clk) begin
        logic ack_now;
        ack_now = bus_req && rst_n && (($urandom % 4) != 0);
        bus_ack = ack_now;
        bus_rdata = pat(bus_addr);
        if (ack_now && bus_we && nlog < 2048) begin
            log_addr[nlog] = bus_addr;
            log_data[nlog] = bus_wdata;
            nlog = nlog + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = 3'd4;
    endtask

    task automatic rd(input logic [2:0] i, output logic [7:0] v);
        reg_idx = i;
        #1;
        v = reg_rdata;
        reg_idx = 3'd4;
    endtask

    task automatic prog(input logic [15:0] s, input logic [15:0] d);
        wr(3'd0, s[15:8]); wr(3'd1, s[7:0]); wr(3'd2, d[15:8]); wr(3'd3, d[7:0]);
    endtask

    task automatic verify_log(input logic [15:0] s, input logic [15:0] d, input int nbytes, input string req);
        int bad = 0;
        check(nlog == nbytes, {req, " byte count"}, nlog, nbytes);
        for (int k = 0; k < nbytes && k < nlog; k++) begin
            logic [15:0] ea;
            logic [15:0] sa;
            ea = {3'b100, d[12:0] + 13'(k)};
            sa = s + 16'(k);
            if (log_addr[k] != ea || log_data[k] != pat(sa)) begin
                if (bad == 0)
                    $display("FAIL %s byte %0d actual=%h/%h expected=%h/%h", req, k,
                             log_addr[k], log_data[k], ea, pat(sa));
                bad++;
            end
        end
        check(bad == 0, {req, " byte content"}, bad, 0);
    endtask

    // general-mode run: returns after the stall falls
    task automatic run_general(input logic [15:0] s, input logic [15:0] d, input logic [7:0] w);
        logic [7:0] v;
        int guard = 0;
        nlog = 0;
        wr(3'd4, w);
        rd(3'd4, v);
        check(v == {1'b0, w[6:0]}, "R4 accepted readback", v, {1'b0, w[6:0]});
        check(cpu_stall == 1'b1, "R6 stall raised", cpu_stall, 1);
        while (cpu_stall && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        verify_log(exp_src(s[15:8], s[7:0]), exp_dst(d[15:8], d[7:0]), (int'(w[6:0]) + 1) * 16, "R5 R6 general copy");
        rd(3'd4, v);
        check(v == 8'hFF, "R8 done readback", v, 8'hFF);
    endtask

    task automatic pulse_chunk(input int target);
        int guard = 0;
        @(negedge clk); hblank = 1'b1;
        @(negedge clk); hblank = 1'b0;
        while (nlog < target && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic run_paced(input logic [15:0] s, input logic [15:0] d, input logic [7:0] w, input bit poke);
        logic [7:0] v;
        int n;
        n = int'(w[6:0]) + 1;
        nlog = 0;
        wr(3'd4, w);
        rd(3'd4, v);
        check(v == {1'b0, w[6:0]}, "R4 paced accepted readback", v, {1'b0, w[6:0]});
        repeat (10) @(negedge clk);
        check(nlog == 0, "R7 quiet before hblank", nlog, 0);
        check(cpu_stall == 1'b0, "R7 no stall", cpu_stall, 0);
        if (poke) begin
            wr(3'd4, 8'h03);
            repeat (6) @(negedge clk);
            rd(3'd4, v);
            check(v == {1'b0, w[6:0]}, "R9 busy write ignored readback", v, {1'b0, w[6:0]});
            check(cpu_stall == 1'b0 && nlog == 0, "R9 busy write no effect", nlog, 0);
        end
        for (int c = 1; c <= n; c++) begin
            pulse_chunk(c * 16);
            check(nlog == c * 16, "R7 sixteen bytes per edge", nlog, c * 16);
            rd(3'd4, v);
            if (c < n) check(v == 8'(n - c - 1), "R7 readback decrement", v, n - c - 1);
            else       check(v == 8'hFF, "R8 paced done readback", v, 8'hFF);
        end
        verify_log(exp_src(s[15:8], s[7:0]), exp_dst(d[15:8], d[7:0]), n * 16, "R5 R7 paced copy");
    endtask

    task automatic run_refused(input logic [15:0] s, input logic [7:0] w, input logic [7:0] exp, input string req);
        logic [7:0] v;
        nlog = 0;
        wr(3'd4, w);
        rd(3'd4, v);
        check(v == exp, req, v, exp);
        repeat (20) @(negedge clk);
        check(nlog == 0 && !cpu_stall && !bus_req, {req, " no transfer"}, nlog, 0);
        if (s == 16'h0) ;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd4, v);
        check(v == 8'hFF, "R1 control readback", v, 8'hFF);
        rd(3'd0, v);
        check(v == 8'h00, "R1 source high readback", v, 0);
        check(!cpu_stall && !bus_req, "R1 stall and bus idle", {cpu_stall, bus_req}, 0);

        // R2: rejected sources, including the top of the window
        prog(16'h9FFF, 16'h0000);
        run_refused(16'h9FFF, 8'h12, 8'h92, "R2 reject top of window");
        prog(16'h8005, 16'h0000);
        run_refused(16'h8005, 8'h85, 8'h85, "R2 reject bottom of window");

        // R3: line-paced with display off
        lcd_on = 1'b0;
        prog(16'h1234, 16'h0000);
        run_refused(16'h1234, 8'hFF, 8'h80, "R3 park wrap");
        run_refused(16'h1234, 8'h85, 8'h86, "R3 park increment");
        // R2 has priority over R3
        prog(16'h9000, 16'h0000);
        run_refused(16'h9000, 8'h81, 8'h81, "R2 reject before park");
        // general mode still runs with display off
        prog(16'h7FFF, 16'h1234);
        run_general(16'h7FFF, 16'h1234, 8'h00);
        lcd_on = 1'b1;

        // R5: source just above the window, destination wraps inside window
        prog(16'hA000, 16'hFFFF);
        run_general(16'hA000, 16'hFFFF, 8'h01);

        // R7, R9: paced copy with a control write while waiting
        prog(16'hC345, 16'h0123);
        run_paced(16'hC345, 16'h0123, 8'h82, 1'b1);

        // random mix
        for (int it = 0; it < 16; it++) begin
            logic [15:0] s, d;
            logic [7:0]  w;
            logic        lcd;
            int          vd;
            s = 16'($urandom);
            if (($urandom % 4) == 0) s = 16'h8000 | 16'($urandom % 16'h2000);
            d = 16'($urandom);
            w = {1'($urandom), 7'($urandom % 4)};
            lcd = 1'(($urandom % 3) != 0);
            lcd_on = lcd;
            prog(s, d);
            vd = exp_verdict(exp_src(s[15:8], s[7:0]), w, lcd);
            if (vd != 0)      run_refused(s, w, exp_rb(vd, w), vd == 1 ? "R2 random reject" : "R3 random park");
            else if (w[7])    run_paced(s, d, w, 1'b0);
            else              run_general(s, d, w);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule